// File: doc/BRIEF.md
# Power-Down Clock Stop Sequencer

This block sits between the internally generated clocks of a multi-output clock generator and its output drivers. It takes an active-low power-down request that may change at any time and stops every output cleanly. Single-ended clocks stop low. Each differential true/complement pair parks in one of two ways, which a per-pair configuration bit selects. Only when every output is parked does the block withdraw the enable of the oscillator/PLL. When the request is released it turns the oscillator back on and drives every differential true leg high. It waits for the PLL's stable indication and then re-enables each output only during the low phase of its own clock, so no runt pulse reaches a pin.

All logic runs on one sampling clock that is much faster than the generated clocks. The generated clocks enter as sampled levels. The oscillator, the PLL and the current-mode drivers are modelled only as an enable output, a stable input and output-enable controls.

Top module: `clkstop_seq`

## Requirements
- R1: The request passes through a two-stage synchronizer, with low meaning power-down. Outputs start to stop only after the synchronized request has been seen low at two consecutive rising edges of pair 0's complement input. A shorter request is ignored: all_running_o stays 1 and every output keeps toggling.
- R2: Once stopping starts, each single-ended output is forced low from the next falling edge of its input clock onward, and its last high phase is never cut short.
- R3: Once stopping starts, each differential pair parks at the next falling edge of its complement input.
- R4: For a parked pair whose park_float_i bit is 0: the true leg is driven (oe 1) at level 1, and the complement leg is tri-stated (oe 0).
- R5: For a parked pair whose park_float_i bit is 1: both legs are tri-stated (both oe 0).
- R6: vco_en_o falls only after every output is parked. While it is low, all_parked_o is 1.
- R7: After the synchronized request is seen high, vco_en_o returns to 1. From the next cycle, every pair drives its true leg high with oe 1, whatever its park_float_i bit, until the pair resumes.
- R8: Outputs stay stopped until pll_lock_i is 1. Each output is then re-enabled only while its input clock is low, so its first high phase is complete.
- R9: After reset, all outputs pass through, vco_en_o is 1, all_running_o is 1 and all_parked_o is 0. all_parked_o means every output is parked, and all_running_o means every output is passing its clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_req_n | input | 1 | Power-down request, active low, asynchronous |
| se_clk_i | input | N_SE | Single-ended source clocks |
| dp_t_i | input | N_DIFF | Differential true source clocks |
| dp_c_i | input | N_DIFF | Differential complement source clocks; bit 0 confirms the request |
| park_float_i | input | N_DIFF | Per-pair park style: 0 true driven high, 1 both legs floating |
| pll_lock_i | input | 1 | PLL reports stable clocks |
| se_clk_o | output | N_SE | Gated single-ended clocks |
| dp_t_o | output | N_DIFF | True leg level |
| dp_c_o | output | N_DIFF | Complement leg level |
| dp_t_oe_o | output | N_DIFF | True leg drive enable |
| dp_c_oe_o | output | N_DIFF | Complement leg drive enable |
| vco_en_o | output | 1 | Oscillator/PLL enable |
| all_parked_o | output | 1 | Every output is parked |
| all_running_o | output | 1 | Every output is running |

## Verification
On every cycle, the assertions check four things. A single-ended output rises or falls only together with its source, so it never produces a truncated or early high phase. A complement leg is released only while its source is low. Parked pairs show the leg enables their park style demands. The oscillator is never off unless everything is parked. Several properties can only be shown by the bench's scenarios against its cycle model: the two-edge confirmation, the rejection of a short request, the order of wake-up, drive-high, lock and resume, and the exact cycle at which each lane stops.

// File: rtl/clkstop_pkg.sv
// Shared state encodings for the power-down clock stop sequencer.
package clkstop_pkg;
    // Sequencer phases, from normal running through power-down and back.
    typedef enum logic [2:0] {
        SQ_RUN   = 3'd0,
        SQ_STOP  = 3'd1,
        SQ_OFF   = 3'd2,
        SQ_WAKE  = 3'd3,
        SQ_START = 3'd4
    } seq_state_t;

    // Per-pair lane state.
    typedef enum logic [1:0] {
        LN_RUN   = 2'd0,
        LN_PARK  = 2'd1,
        LN_DRIVE = 2'd2
    } pair_state_t;
endpackage

// File: rtl/clkstop_sync.sv
// Multi-stage level synchronizer.
// Assumes: STAGES >= 2; the reset value sets the idle (no request) level.
module clkstop_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_q;

    // Shift the asynchronous level through the stages.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= {sh_q[STAGES-2:0], d_i};
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/clkstop_ctrl.sv
// Request confirmation and power sequencing state machine.
// Assumes: ref_c_i is a sampled clock much slower than clk; the lanes
// report their parked/running status as registered levels.
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int CONFIRM = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_low_i,
    input  logic ref_c_i,
    input  logic pll_lock_i,
    input  logic all_parked_i,
    input  logic all_running_i,
    output logic stop_cmd_o,
    output logic drive_hi_o,
    output logic start_cmd_o,
    output logic vco_en_o
);
    localparam int CW = $clog2(CONFIRM + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(CONFIRM);

    logic          ref_prev_q;
    logic [CW-1:0] cnt_q;
    logic          ref_rise;
    logic          confirmed;
    seq_state_t    st_q, st_d;

    assign ref_rise  = ref_c_i && !ref_prev_q;
    assign confirmed = (cnt_q == CNT_MAX);

    // Remember the previous reference sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_prev_q <= 1'b0;
        else        ref_prev_q <= ref_c_i;
    end

    // Count consecutive reference rising edges that see the request low.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (!req_low_i)                 cnt_q <= '0;
        else if (ref_rise && !confirmed)     cnt_q <= cnt_q + 1'b1;
    end

    // Next-phase selection.
    always_comb begin
        st_d = st_q;
        case (st_q)
            SQ_RUN:   if (confirmed)     st_d = SQ_STOP;
            SQ_STOP:  if (all_parked_i)  st_d = SQ_OFF;
            SQ_OFF:   if (!req_low_i)    st_d = SQ_WAKE;
            SQ_WAKE:  if (pll_lock_i)    st_d = SQ_START;
            SQ_START: if (all_running_i) st_d = SQ_RUN;
            default:                     st_d = SQ_RUN;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SQ_RUN;
        else        st_q <= st_d;
    end

    assign stop_cmd_o  = (st_q == SQ_STOP);
    assign drive_hi_o  = (st_q == SQ_WAKE);
    assign start_cmd_o = (st_q == SQ_START);
    assign vco_en_o    = (st_q != SQ_OFF);
endmodule

// File: rtl/clkstop_se_lane.sv
// Glitch-free gate for one single-ended clock.
// Stops on a falling source edge and restarts only while the source is low.
// Assumes: the source is sampled by clk at least twice per phase.
module clkstop_se_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_i,
    input  logic stop_i,
    input  logic start_i,
    output logic clk_o,
    output logic run_o
);
    logic prev_q;
    logic run_q;

    // Previous source sample.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= clk_i;
    end

    // Run flag: cleared at a falling edge, set during a low phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  run_q <= 1'b1;
        else if (run_q && stop_i && prev_q && !clk_i) run_q <= 1'b0;
        else if (!run_q && start_i && !clk_i)         run_q <= 1'b1;
    end

    assign clk_o = clk_i & run_q;
    assign run_o = run_q;
endmodule

// File: rtl/clkstop_diff_lane.sv
// Park/resume control for one differential true/complement pair.
// Parks at a falling complement edge. It either holds true high with the
// complement floating, or floats both legs. It drives true high before
// resuming during a low complement phase.
// Assumes: float_i is not changed while the pair is in transit.
module clkstop_diff_lane
    import clkstop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic t_i,
    input  logic c_i,
    input  logic float_i,
    input  logic stop_i,
    input  logic drive_i,
    input  logic start_i,
    output logic t_o,
    output logic c_o,
    output logic t_oe_o,
    output logic c_oe_o,
    output logic parked_o,
    output logic running_o
);
    logic        cprev_q;
    pair_state_t st_q;

    // Previous complement sample.
    always_ff @(posedge clk) begin
        if (!rst_n) cprev_q <= 1'b0;
        else        cprev_q <= c_i;
    end

    // Lane state transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= LN_RUN;
        end else begin
            case (st_q)
                LN_RUN:   if (stop_i && cprev_q && !c_i) st_q <= LN_PARK;
                LN_PARK:  if (drive_i)                   st_q <= LN_DRIVE;
                LN_DRIVE: if (start_i && !c_i)           st_q <= LN_RUN;
                default:                                 st_q <= LN_RUN;
            endcase
        end
    end

    // Leg levels and enables per state.
    always_comb begin
        t_o    = 1'b0;
        c_o    = 1'b0;
        t_oe_o = 1'b0;
        c_oe_o = 1'b0;
        case (st_q)
            LN_RUN: begin
                t_o    = t_i;
                c_o    = c_i;
                t_oe_o = 1'b1;
                c_oe_o = 1'b1;
            end
            LN_PARK: begin
                t_o    = !float_i;
                t_oe_o = !float_i;
            end
            LN_DRIVE: begin
                t_o    = 1'b1;
                t_oe_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign parked_o  = (st_q == LN_PARK);
    assign running_o = (st_q == LN_RUN);
endmodule

// File: rtl/clkstop_seq.sv
// Power-down clock stop sequencer top.
// Synchronizes the request, builds one gate per single-ended clock and one
// park controller per differential pair, and sequences the oscillator enable.
// Assumes: all source clocks are oversampled by clk; pair 0's complement is
// the confirmation reference.
module clkstop_seq #(
    parameter int N_SE    = 4,
    parameter int N_DIFF  = 2,
    parameter int SYNC_ST = 2,
    parameter int CONFIRM = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_req_n,
    input  logic [N_SE-1:0]   se_clk_i,
    input  logic [N_DIFF-1:0] dp_t_i,
    input  logic [N_DIFF-1:0] dp_c_i,
    input  logic [N_DIFF-1:0] park_float_i,
    input  logic              pll_lock_i,
    output logic [N_SE-1:0]   se_clk_o,
    output logic [N_DIFF-1:0] dp_t_o,
    output logic [N_DIFF-1:0] dp_c_o,
    output logic [N_DIFF-1:0] dp_t_oe_o,
    output logic [N_DIFF-1:0] dp_c_oe_o,
    output logic              vco_en_o,
    output logic              all_parked_o,
    output logic              all_running_o
);
    logic              req_sync;
    logic              stop_cmd, drive_hi, start_cmd;
    logic [N_SE-1:0]   se_run;
    logic [N_DIFF-1:0] dp_parked, dp_running;

    clkstop_sync #(.STAGES(SYNC_ST), .RST_VAL(1'b1)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pd_req_n),
        .q_o   (req_sync)
    );

    clkstop_ctrl #(.CONFIRM(CONFIRM)) i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_low_i     (!req_sync),
        .ref_c_i       (dp_c_i[0]),
        .pll_lock_i    (pll_lock_i),
        .all_parked_i  (all_parked_o),
        .all_running_i (all_running_o),
        .stop_cmd_o    (stop_cmd),
        .drive_hi_o    (drive_hi),
        .start_cmd_o   (start_cmd),
        .vco_en_o      (vco_en_o)
    );

    for (genvar i = 0; i < N_SE; i++) begin : g_se
        clkstop_se_lane i_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .clk_i   (se_clk_i[i]),
            .stop_i  (stop_cmd),
            .start_i (start_cmd),
            .clk_o   (se_clk_o[i]),
            .run_o   (se_run[i])
        );
    end

    for (genvar j = 0; j < N_DIFF; j++) begin : g_dp
        clkstop_diff_lane i_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .t_i       (dp_t_i[j]),
            .c_i       (dp_c_i[j]),
            .float_i   (park_float_i[j]),
            .stop_i    (stop_cmd),
            .drive_i   (drive_hi),
            .start_i   (start_cmd),
            .t_o       (dp_t_o[j]),
            .c_o       (dp_c_o[j]),
            .t_oe_o    (dp_t_oe_o[j]),
            .c_oe_o    (dp_c_oe_o[j]),
            .parked_o  (dp_parked[j]),
            .running_o (dp_running[j])
        );
    end

    assign all_parked_o  = (~|se_run) && (&dp_parked);
    assign all_running_o = (&se_run) && (&dp_running);
endmodule

// File: rtl/clkstop_seq_chk.sv
// Property checker for clkstop_seq, attached by bind.
module clkstop_seq_chk #(
    parameter int N_SE   = 4,
    parameter int N_DIFF = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SE-1:0]   se_clk_i,
    input logic [N_DIFF-1:0] dp_c_i,
    input logic [N_DIFF-1:0] park_float_i,
    input logic [N_SE-1:0]   se_clk_o,
    input logic [N_DIFF-1:0] dp_t_o,
    input logic [N_DIFF-1:0] dp_t_oe_o,
    input logic [N_DIFF-1:0] dp_c_oe_o,
    input logic              vco_en_o,
    input logic              all_parked_o,
    input logic              all_running_o
);
    for (genvar i = 0; i < N_SE; i++) begin : g_se
        // R2
        se_stop_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(se_clk_o[i]) |-> $fell(se_clk_i[i]));
        // R8
        se_start_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(se_clk_o[i]) |-> $rose(se_clk_i[i]));
    end

    for (genvar j = 0; j < N_DIFF; j++) begin : g_dp
        // R3
        dp_park_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(dp_c_oe_o[j]) |-> !dp_c_i[j]);
        // R4
        dp_park_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (all_parked_o && !park_float_i[j]) |-> (dp_t_oe_o[j] && dp_t_o[j] && !dp_c_oe_o[j]));
        // R5
        dp_park_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (all_parked_o && park_float_i[j]) |-> (!dp_t_oe_o[j] && !dp_c_oe_o[j]));
        // R7
        dp_wake_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(vco_en_o) |=> (dp_t_oe_o[j] && dp_t_o[j]));
    end

    // R6
    vco_off_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vco_en_o |-> all_parked_o);
    // R9
    status_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(all_parked_o && all_running_o));
endmodule

bind clkstop_seq clkstop_seq_chk #(.N_SE(N_SE), .N_DIFF(N_DIFF)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .se_clk_i      (se_clk_i),
    .dp_c_i        (dp_c_i),
    .park_float_i  (park_float_i),
    .se_clk_o      (se_clk_o),
    .dp_t_o        (dp_t_o),
    .dp_t_oe_o     (dp_t_oe_o),
    .dp_c_oe_o     (dp_c_oe_o),
    .vco_en_o      (vco_en_o),
    .all_parked_o  (all_parked_o),
    .all_running_o (all_running_o)
);

// File: tb/test_clkstop_seq.sv
module test_clkstop_seq;
    localparam int N_SE   = 4;
    localparam int N_DIFF = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pd_req_n = 1'b1;
    logic [N_SE-1:0]   se_clk_i = '0;
    logic [N_DIFF-1:0] dp_t_i = '0;
    logic [N_DIFF-1:0] dp_c_i = '1;
    logic [N_DIFF-1:0] park_float_i = '0;
    logic              pll_lock_i = 1'b0;
    logic [N_SE-1:0]   se_clk_o;
    logic [N_DIFF-1:0] dp_t_o, dp_c_o, dp_t_oe_o, dp_c_oe_o;
    logic              vco_en_o, all_parked_o, all_running_o;

    clkstop_seq #(.N_SE(N_SE), .N_DIFF(N_DIFF)) i_clkstop_seq (
        .clk(clk), .rst_n(rst_n), .pd_req_n(pd_req_n),
        .se_clk_i(se_clk_i), .dp_t_i(dp_t_i), .dp_c_i(dp_c_i),
        .park_float_i(park_float_i), .pll_lock_i(pll_lock_i),
        .se_clk_o(se_clk_o), .dp_t_o(dp_t_o), .dp_c_o(dp_c_o),
        .dp_t_oe_o(dp_t_oe_o), .dp_c_oe_o(dp_c_oe_o), .vco_en_o(vco_en_o),
        .all_parked_o(all_parked_o), .all_running_o(all_running_o)
    );

    always #4 clk = ~clk;   // 125 MHz

    int n_chk = 0, n_fail = 0, cyc = 0, lock_cnt = 0, lock_dly = 10;
    bit cmp_on = 1'b0, done = 1'b0;

    // Behavioural reference: phase 0 run, 1 stopping, 2 off, 3 waking, 4 starting.
    int m_st, m_cnt, m_st_old;
    bit m_s1, m_s2, m_refprev, m_allp, m_allr;
    bit m_run [N_SE];
    bit m_sprev [N_SE];
    int m_ds [N_DIFF];      // 0 running, 1 parked, 2 driven high
    bit m_cprev [N_DIFF];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_s1 = 1; m_s2 = 1; m_refprev = 0;
            foreach (m_run[i]) begin m_run[i] = 1; m_sprev[i] = 0; end
            foreach (m_ds[j]) begin m_ds[j] = 0; m_cprev[j] = 0; end
        end else begin
            m_allp = 1; m_allr = 1;
            foreach (m_run[i]) begin
                if (m_run[i]) m_allp = 0; else m_allr = 0;
            end
            foreach (m_ds[j]) begin
                if (m_ds[j] != 1) m_allp = 0;
                if (m_ds[j] != 0) m_allr = 0;
            end
            m_st_old = m_st;
            case (m_st_old)
                0: if (m_cnt == 2) m_st = 1;
                1: if (m_allp) m_st = 2;
                2: if (m_s2) m_st = 3;
                3: if (pll_lock_i) m_st = 4;
                4: if (m_allr) m_st = 0;
                default: m_st = 0;
            endcase
            if (m_s2) m_cnt = 0;
            else if (dp_c_i[0] && !m_refprev && m_cnt < 2) m_cnt++;
            m_refprev = dp_c_i[0];
            foreach (m_run[i]) begin
                if (m_run[i] && m_st_old == 1 && m_sprev[i] && !se_clk_i[i]) m_run[i] = 0;
                else if (!m_run[i] && m_st_old == 4 && !se_clk_i[i]) m_run[i] = 1;
                m_sprev[i] = se_clk_i[i];
            end
            foreach (m_ds[j]) begin
                if (m_ds[j] == 0 && m_st_old == 1 && m_cprev[j] && !dp_c_i[j]) m_ds[j] = 1;
                else if (m_ds[j] == 1 && m_st_old == 3) m_ds[j] = 2;
                else if (m_ds[j] == 2 && m_st_old == 4 && !dp_c_i[j]) m_ds[j] = 0;
                m_cprev[j] = dp_c_i[j];
            end
            m_s2 = m_s1; m_s1 = pd_req_n;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic compare();
        logic [N_SE-1:0] e_se;
        logic [N_DIFF-1:0] e_t, e_c, e_toe, e_coe;
        bit e_allp, e_allr;
        e_allp = 1; e_allr = 1;
        for (int i = 0; i < N_SE; i++) begin
            e_se[i] = se_clk_i[i] & m_run[i];
            if (m_run[i]) e_allp = 0; else e_allr = 0;
        end
        for (int j = 0; j < N_DIFF; j++) begin
            e_t[j] = 0; e_c[j] = 0; e_toe[j] = 0; e_coe[j] = 0;
            if (m_ds[j] == 0) begin
                e_t[j] = dp_t_i[j]; e_c[j] = dp_c_i[j]; e_toe[j] = 1; e_coe[j] = 1;
            end else if (m_ds[j] == 1) begin
                e_t[j] = !park_float_i[j]; e_toe[j] = !park_float_i[j];
            end else begin
                e_t[j] = 1; e_toe[j] = 1;
            end
            if (m_ds[j] != 1) e_allp = 0;
            if (m_ds[j] != 0) e_allr = 0;
        end
        n_chk++;
        if (se_clk_o !== e_se || dp_t_o !== e_t || dp_c_o !== e_c ||
            dp_t_oe_o !== e_toe || dp_c_oe_o !== e_coe ||
            vco_en_o !== (m_st != 2) || all_parked_o !== e_allp || all_running_o !== e_allr) begin
            n_fail++;
            $display("FAIL R1,R2,R3,R4,R5,R6,R7,R8,R9 cycle %0d: actual se=%h t=%h c=%h toe=%h coe=%h vco=%b p=%b r=%b expected se=%h t=%h c=%h toe=%h coe=%h vco=%b p=%b r=%b",
                     cyc, se_clk_o, dp_t_o, dp_c_o, dp_t_oe_o, dp_c_oe_o, vco_en_o, all_parked_o, all_running_o,
                     e_se, e_t, e_c, e_toe, e_coe, (m_st != 2), e_allp, e_allr);
        end
    endtask

    // One cycle: compare at the falling edge, then move the inputs.
    task automatic step();
        @(negedge clk);
        if (cmp_on) compare();
        cyc++;
        for (int i = 0; i < N_SE; i++) se_clk_i[i] = ((cyc / (2 + i)) % 2) != 0;
        for (int j = 0; j < N_DIFF; j++) begin
            dp_t_i[j] = ((cyc / (3 + j)) % 2) != 0;
            dp_c_i[j] = !dp_t_i[j];
        end
        if (vco_en_o) lock_cnt++; else lock_cnt = 0;
        pll_lock_i = (lock_cnt >= lock_dly);
    endtask

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // One full power-down and release cycle with the given park styles.
    task automatic power_cycle(input logic [N_DIFF-1:0] fl, input int dly);
        int n;
        bit bad;
        park_float_i = fl;
        lock_dly = dly;
        pd_req_n = 1'b0;
        n = 0;
        while (vco_en_o && n < 300) begin step(); n++; end
        check(!vco_en_o, "R6 oscillator turned off", vco_en_o, 0);
        check(all_parked_o, "R6 all parked while off", all_parked_o, 1);
        check(se_clk_o == '0, "R2 single-ended held low", se_clk_o, 0);
        for (int j = 0; j < N_DIFF; j++) begin
            if (fl[j]) check(dp_t_oe_o[j] == 0 && dp_c_oe_o[j] == 0, "R5 both legs floating",
                             {dp_t_oe_o[j], dp_c_oe_o[j]}, 0);
            else check(dp_t_oe_o[j] && dp_t_o[j] && !dp_c_oe_o[j], "R4 true high, complement floating",
                       {dp_t_oe_o[j], dp_t_o[j], dp_c_oe_o[j]}, 3'b110);
        end
        repeat (30) step();
        check(!vco_en_o, "R6 stays off while request held", vco_en_o, 0);
        pd_req_n = 1'b1;
        n = 0;
        while (!vco_en_o && n < 20) begin step(); n++; end
        check(vco_en_o, "R7 oscillator back on", vco_en_o, 1);
        step();
        check(dp_t_oe_o == '1 && dp_t_o == '1 && dp_c_oe_o == '0, "R7 pairs drive true high",
              {dp_t_oe_o, dp_t_o, dp_c_oe_o}, {{N_DIFF{1'b1}}, {N_DIFF{1'b1}}, {N_DIFF{1'b0}}});
        bad = 0; n = 0;
        while (!all_running_o && n < 300) begin
            if (!pll_lock_i && (se_clk_o != '0 || dp_c_oe_o != '0)) bad = 1;
            step(); n++;
        end
        check(!bad, "R8 nothing resumes before lock", bad, 0);
        check(all_running_o, "R8 all outputs resumed", all_running_o, 1);
        repeat (20) step();
    endtask

    initial begin
        bit stayed;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        cmp_on = 1'b1;
        // R9 reset state
        check(all_running_o && !all_parked_o && vco_en_o, "R9 reset state",
              {all_running_o, all_parked_o, vco_en_o}, 3'b101);
        repeat (60) step();
        // R1 short request: sees at most one reference edge
        pd_req_n = 1'b0;
        repeat (4) step();
        pd_req_n = 1'b1;
        stayed = 1;
        repeat (40) begin step(); if (!all_running_o || !vco_en_o) stayed = 0; end
        check(stayed, "R1 short request ignored", stayed, 1);
        // R1 just-long-enough check via the model, then full cycles
        power_cycle(2'b10, 10);
        power_cycle(2'b01, 25);
        power_cycle(2'b11, 3);
        power_cycle(2'b00, 40);
        done = 1'b1;
        report();
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end
endmodule